// File: doc/BRIEF.md
# Alarm Clock Mode Controller

This block is the control state machine of a 24-hour alarm clock. It takes single-cycle pulses from five debounced buttons (center, up, down, left, right), two phase pulses that mark the half-periods of a 1 Hz and a 5 Hz square wave, and a level that is high while the running time equals the alarm time. From these it keeps one of three modes: run, adjust and ringing.

In run mode the clock keeps time and the decimal point blinks. The center button moves to adjust mode. There the left and right buttons choose one of four fields, and the up and down buttons send one-cycle increment and decrement strobes to the counter of the chosen field. When the time matches the alarm in run mode, the controller rings. It blinks the mode LED and pulses the buzzer until a button is pressed. That press only silences the alarm, and the alarm does not ring again while the same match lasts.

The counters, debouncing and display multiplexing sit outside this block. The asynchronous reset is released through a small synchronizer inside the block.

Top module: `alarm_mode_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in run mode with alarm minute selected: led_mode 0, led_field 0, dp_blink 1, buzzer 0, inc_stb 0, dec_stb 0.
- R2: A center pulse in run mode enters adjust mode, and a center pulse in adjust mode returns to run mode. Both changes are visible in the cycle after the pulse.
- R3: In run mode led_mode is 0 and dp_blink is 1. In adjust mode led_mode is 1 and dp_blink is 0. In ringing mode dp_blink is 1.
- R4: In adjust mode a right pulse steps the selection forward: alarm minute (led_field bit 0), alarm hour (bit 1), time minute (bit 2), time hour (bit 3), then back to alarm minute.
- R5: In adjust mode a left pulse steps the selection backward through the same ring. Left and right together leave it unchanged. Left and right outside adjust mode do not change the selection.
- R6: In adjust mode exactly one led_field bit is set, the one for the selected field. In other modes led_field is 0.
- R7: An up pulse in adjust mode gives inc_stb high for exactly the next cycle, and a down pulse gives dec_stb in the same way. Up and down together give neither strobe. Neither strobe is ever produced outside adjust mode.
- R8: In run mode, when time_eq is high and the alarm is armed, the block enters ringing mode in the next cycle. It never enters ringing from adjust mode.
- R9: In ringing mode led_mode starts at 1 and flips on each half_1hz pulse, and buzzer starts at 1 and flips on each half_5hz pulse. Outside ringing, buzzer is 0.
- R10: Any button pulse in ringing mode returns to run mode in the next cycle. It produces no strobe and does not change the selection.
- R11: After a silence the alarm is disarmed. It stays in run mode while time_eq stays high, and it re-arms only after a cycle with time_eq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_center | input | 1 | Center button pulse |
| btn_up | input | 1 | Up button pulse |
| btn_down | input | 1 | Down button pulse |
| btn_left | input | 1 | Left button pulse |
| btn_right | input | 1 | Right button pulse |
| half_1hz | input | 1 | Pulse at each half-period of the 1 Hz blink |
| half_5hz | input | 1 | Pulse at each half-period of the 5 Hz buzz |
| time_eq | input | 1 | High while current time equals alarm time |
| led_mode | output | 1 | Mode LED |
| led_field | output | 4 | One-hot selected-field LEDs |
| dp_blink | output | 1 | Decimal point blink enable |
| buzzer | output | 1 | Buzzer drive |
| inc_stb | output | 1 | Increment strobe for the selected field |
| dec_stb | output | 1 | Decrement strobe for the selected field |

## Verification
Directed sequences first walk the field ring through more than one full turn in each direction. This separates a correct wrap from an off-by-one step or a reversed order. They also press left and right together and press both outside adjust mode, to tell "ignored" apart from "stepped and stepped back". Match scenarios hold time_eq high across an adjust session, a silence and a later re-arm. These show whether entry into ringing depends on the armed state and on the mode, and whether the silencing press leaks into a mode change or a strobe. Random pulses on every input, with time_eq held in long runs, then mix simultaneous buttons, ticks and matches in every mode.

// File: rtl/alarm_ctrl_pkg.sv
package alarm_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_ADJ  = 2'd1,
    MODE_RING = 2'd2
  } mode_e;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import alarm_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  btn_ctr,
  input  logic  any_btn,
  input  logic  time_eq,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;
  logic  armed_q, armed_d;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_RUN: begin
        if (btn_ctr)                mode_d = MODE_ADJ;
        else if (time_eq && armed_q) mode_d = MODE_RING;
      end
      MODE_ADJ:  if (btn_ctr) mode_d = MODE_RUN;
      MODE_RING: if (any_btn) mode_d = MODE_RUN;
      default:   mode_d = MODE_RUN;
    endcase
  end

  always_comb begin
    armed_d = armed_q;
    if (mode_q == MODE_RING && any_btn) armed_d = 1'b0;
    else if (!time_eq)                  armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RUN;
      armed_q <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      armed_q <= armed_d;
    end
  end

  assign mode_o = mode_q;

  assert_center_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ADJ && btn_ctr) |=> (mode_q == MODE_RUN));
  assert_adj_no_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ADJ) |=> (mode_q != MODE_RING));
  assert_ring_silence_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RING && any_btn) |=> (mode_q == MODE_RUN));
  assert_no_retrigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RING && any_btn) ##1 (time_eq && !any_btn) |=> (mode_q == MODE_RUN));
endmodule

// File: rtl/field_sel.sv
module field_sel #(
  parameter int NUM_FIELDS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adj,
  input  logic                  step_fwd,
  input  logic                  step_back,
  output logic [NUM_FIELDS-1:0] led_o
);
  localparam int SEL_W = $clog2(NUM_FIELDS);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_FIELDS - 1);

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_en;

  assign sel_en = adj && (step_fwd ^ step_back);

  always_comb begin
    if (step_fwd) sel_d = (sel_q == LAST) ? '0 : sel_q + 1'b1;
    else          sel_d = (sel_q == '0) ? LAST : sel_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_led
    assign led_o[i] = adj && (sel_q == SEL_W'(i));
  end

  assert_field_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adj |-> ($countones(led_o) == 1));
  assert_field_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adj |-> (led_o == '0));
endmodule

// File: rtl/ring_phase.sv
module ring_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic ringing,
  input  logic half_slow,
  input  logic half_fast,
  output logic slow_on,
  output logic fast_on
);
  logic slow_q, fast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      fast_q <= 1'b0;
    end else if (!ringing) begin
      slow_q <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      if (half_slow) slow_q <= ~slow_q;
      if (half_fast) fast_q <= ~fast_q;
    end
  end

  assign slow_on = ringing && !slow_q;
  assign fast_on = ringing && !fast_q;
endmodule

// File: rtl/alarm_mode_ctrl.sv
module alarm_mode_ctrl
  import alarm_ctrl_pkg::*;
#(
  parameter int NUM_FIELDS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  btn_center,
  input  logic                  btn_up,
  input  logic                  btn_down,
  input  logic                  btn_left,
  input  logic                  btn_right,
  input  logic                  half_1hz,
  input  logic                  half_5hz,
  input  logic                  time_eq,
  output logic                  led_mode,
  output logic [NUM_FIELDS-1:0] led_field,
  output logic                  dp_blink,
  output logic                  buzzer,
  output logic                  inc_stb,
  output logic                  dec_stb
);
  logic  rst_s_n;
  logic  any_btn;
  mode_e mode;
  logic  in_adj, in_ring;
  logic  blink_on, buzz_on;
  logic  inc_q, dec_q, inc_d, dec_d;

  rst_release_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  assign any_btn = btn_center | btn_up | btn_down | btn_left | btn_right;

  mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .btn_ctr(btn_center), .any_btn(any_btn),
    .time_eq(time_eq), .mode_o(mode));

  assign in_adj  = (mode == MODE_ADJ);
  assign in_ring = (mode == MODE_RING);

  field_sel #(.NUM_FIELDS(NUM_FIELDS)) u_field (
    .clk(clk), .rst_n(rst_s_n), .adj(in_adj), .step_fwd(btn_right),
    .step_back(btn_left), .led_o(led_field));

  ring_phase u_phase (
    .clk(clk), .rst_n(rst_s_n), .ringing(in_ring), .half_slow(half_1hz),
    .half_fast(half_5hz), .slow_on(blink_on), .fast_on(buzz_on));

  assign inc_d = in_adj && btn_up && !btn_down;
  assign dec_d = in_adj && btn_down && !btn_up;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      inc_q <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      inc_q <= inc_d;
      dec_q <= dec_d;
    end
  end

  assign inc_stb  = inc_q;
  assign dec_stb  = dec_q;
  assign led_mode = in_adj | blink_on;
  assign dp_blink = !in_adj;
  assign buzzer   = buzz_on;

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(inc_stb && dec_stb));
  assert_strobe_adj_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (inc_stb || dec_stb) |-> ($past(mode) == MODE_ADJ));
  assert_buzz_ring_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    buzzer |-> in_ring);
  assert_ring_entry_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(in_ring) |-> (led_mode && buzzer));
endmodule

// File: tb/alarm_mode_ctrl_tb_top.sv
module alarm_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic b_c, b_u, b_d, b_l, b_r, t1, t5, eq;
  logic led_mode, dp_blink, buzzer, inc_stb, dec_stb;
  logic [3:0] led_field;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench model: 0 run, 1 adjust, 2 ringing
  int   m_mode;
  bit   m_armed, m_inc, m_dec, m_p1, m_p5;
  int   m_sel;

  always #5 clk = ~clk;

  alarm_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .btn_center(b_c), .btn_up(b_u), .btn_down(b_d),
    .btn_left(b_l), .btn_right(b_r), .half_1hz(t1), .half_5hz(t5), .time_eq(eq),
    .led_mode(led_mode), .led_field(led_field), .dp_blink(dp_blink),
    .buzzer(buzzer), .inc_stb(inc_stb), .dec_stb(dec_stb));

  function automatic bit exp_led_mode();
    return (m_mode == 1) || (m_mode == 2 && !m_p1);
  endfunction
  function automatic bit exp_buzzer();
    return (m_mode == 2) && !m_p5;
  endfunction
  function automatic logic [3:0] exp_field();
    return (m_mode == 1) ? (4'b0001 << m_sel) : 4'b0000;
  endfunction

  task automatic chk1(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    n_tests++;
    if (led_field !== exp_field()) begin
      n_fail++;
      $display("FAIL %s R6 led_field actual=%b expected=%b", tag, led_field, exp_field());
    end
    chk1(tag, (m_mode == 2) ? "R9 led_mode" : "R3 led_mode", led_mode, exp_led_mode());
    chk1(tag, "R3 dp_blink", dp_blink, m_mode != 1);
    chk1(tag, "R9 buzzer", buzzer, exp_buzzer());
    chk1(tag, "R7 inc_stb", inc_stb, m_inc);
    chk1(tag, "R7 dec_stb", dec_stb, m_dec);
  endtask

  task automatic cyc(input bit c, u, d, l, r, s1, s5, e, input string tag);
    bit any;
    int nm;
    @(negedge clk);
    check_all(tag);
    b_c = c; b_u = u; b_d = d; b_l = l; b_r = r; t1 = s1; t5 = s5; eq = e;
    any = c | u | d | l | r;
    nm = m_mode;
    case (m_mode)
      0: if (c) nm = 1; else if (e && m_armed) nm = 2;
      1: if (c) nm = 0;
      default: if (any) nm = 0;
    endcase
    @(posedge clk);
    if (m_mode == 2 && any) m_armed = 0; else if (!e) m_armed = 1;
    if (m_mode == 1 && (r ^ l)) m_sel = r ? (m_sel + 1) % 4 : (m_sel + 3) % 4;
    m_inc = (m_mode == 1) && u && !d;
    m_dec = (m_mode == 1) && d && !u;
    if (m_mode != 2) begin m_p1 = 0; m_p5 = 0; end
    else begin if (s1) m_p1 = ~m_p1; if (s5) m_p5 = ~m_p5; end
    m_mode = nm;
  endtask

  task automatic idle(input int n, input bit e, input string tag);
    for (int i = 0; i < n; i++) cyc(0,0,0,0,0,0,0,e,tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; {b_c, b_u, b_d, b_l, b_r, t1, t5, eq} = '0;
    m_mode = 0; m_armed = 1; m_sel = 0; m_inc = 0; m_dec = 0; m_p1 = 0; m_p5 = 0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    idle(4, 0, "R1 after release");

    // R2 / R3: mode toggle
    cyc(1,0,0,0,0,0,0,0,"R2 enter adjust");
    idle(2, 0, "R3 adjust steady");
    cyc(1,0,0,0,0,0,0,0,"R2 leave adjust");
    idle(2, 0, "R3 run");

    // R4: forward ring with wrap
    cyc(1,0,0,0,0,0,0,0,"R2");
    for (int i = 0; i < 6; i++) cyc(0,0,0,0,1,0,0,0,"R4 step forward");
    // R5: backward, both, ignored outside adjust
    for (int i = 0; i < 6; i++) cyc(0,0,0,1,0,0,0,0,"R5 step back");
    cyc(0,0,0,1,1,0,0,0,"R5 left and right");
    cyc(1,0,0,0,0,0,0,0,"R5 exit");
    cyc(0,0,0,0,1,0,0,0,"R5 right in run");
    cyc(0,0,0,1,0,0,0,0,"R5 left in run");
    cyc(1,0,0,0,0,0,0,0,"R5 re-enter");
    idle(1, 0, "R5 selection kept");

    // R7: strobes
    cyc(0,1,0,0,0,0,0,0,"R7 up");
    cyc(0,0,1,0,0,0,0,0,"R7 down");
    cyc(0,1,1,0,0,0,0,0,"R7 up and down");
    cyc(0,1,0,0,0,0,0,0,"R7 up again");
    cyc(0,1,0,0,0,0,0,0,"R7 up back to back");
    idle(2, 0, "R7 strobe ends");

    // R8: match in adjust does not ring, then rings in run
    idle(3, 1, "R8 match in adjust");
    cyc(1,0,0,0,0,0,0,1,"R8 exit with match");
    idle(2, 1, "R8 ringing");
    // R9: phases
    for (int i = 0; i < 8; i++) cyc(0,0,0,0,0,i % 3 == 0, i % 2 == 0, 1, "R9 ring phases");
    // R10: silence with up, no strobe
    cyc(0,1,0,0,0,0,0,1,"R10 silence");
    // R11: no retrigger during same match
    idle(5, 1, "R11 held match");
    idle(1, 0, "R11 rearm");
    idle(3, 1, "R11 new match");
    cyc(1,0,0,0,0,1,1,1,"R10 center silences");
    idle(3, 1, "R11 still disarmed");
    cyc(0,0,0,0,1,0,0,0,"R10 right after silence");
    idle(2, 0, "R11");

    // random mix
    begin
      bit e = 0;
      for (int k = 0; k < 4000; k++) begin
        bit c, u, d, l, r;
        if ($urandom_range(0, 19) == 0) e = ~e;
        c = ($urandom_range(0, 15) == 0);
        u = ($urandom_range(0, 5) == 0);
        d = ($urandom_range(0, 5) == 0);
        l = ($urandom_range(0, 6) == 0);
        r = ($urandom_range(0, 6) == 0);
        if ($urandom_range(0, 3) != 0) begin c = 0; u = 0; d = 0; l = 0; r = 0; end
        cyc(c, u, d, l, r, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 0, e, "random");
      end
    end
    @(negedge clk);
    check_all("final");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule